// File: doc/BRIEF.md
# Parallel NOR Flash Erase Command Front End

This block models how a parallel NOR flash device interprets erase commands. It watches single-cycle write strobes carrying an address and a data word. It recognises the unlock-guarded six-write sequences that request either a whole-device erase or a sector erase. After a sector erase request it holds an acceptance window open, so that further sectors can be queued. When the window lapses it runs a fixed-length busy phase that stands in for the physical erase. During the window and the busy phase, a read returns a status byte in every byte lane instead of array data.

Array contents live outside the block. The array's read word enters on `arr_rdata`, and the block either passes it through or overrides it with all ones for sectors that have been erased. A one-cycle `tick` pulse is the timebase. Both the window length and the busy length are counted in ticks and set by parameters.

Top module: `nor_erase_front`

## Requirements
- R1: After reset, a read returns `arr_rdata` unchanged and no sector is marked erased.
- R2: The writes (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55), (0x555,0x10) start a whole-device erase at once. Only the address bits below the sector field are compared, and the command byte is always lane 0, `wr_data[7:0]`. The next status read shows bit 3 = 1.
- R3: A write whose address or data does not match the expected unlock or setup cycle returns the block to array-read mode. A later write can only start a new sequence from its first cycle.
- R4: If the first five cycles of R2 are followed by a write of data 0x30, the acceptance window opens for the sector given by the top SW address bits (`wr_addr[15:13]` by default). Status reads then show bit 3 = 0.
- R5: The window closes and the busy phase begins on the WIN_TICKS-th tick that arrives with no write since the window was last started. Reads after that edge show bit 3 = 1.
- R6: Inside the window, each write of data 0x30 adds the addressed sector to the pending set and restarts the tick count of the window.
- R7: Inside the window, a write of any data other than 0x30 drops every pending sector and returns the block to array-read mode, with no erase.
- R8: During the busy phase, every write is ignored. It neither adds sectors nor changes the busy duration.
- R9: In window or busy mode, each byte lane of a read holds bit 7 = 0, bit 6 = a toggle that flips after every such read, bit 3 = window closed, and zero in every other bit.
- R10: On the ERASE_TICKS-th tick of the busy phase, the block returns to array-read mode. From then on, reads in erased sectors return all ones, and reads in other sectors return `arr_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Timebase pulse for window and busy timing |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | AW | Write address |
| wr_data | input | 8*LANES | Write data; the command byte is in lane 0 |
| rd_en | input | 1 | Read strobe; in status mode it advances the toggle bit |
| rd_addr | input | AW | Read address; its sector field selects the erased override |
| arr_rdata | input | 8*LANES | Word read from the external array |
| rd_data | output | 8*LANES | Read result: array data, all ones, or the status byte |

## Verification
The read path is combinational. A read's result is due in the same cycle as `rd_en`, and the bench samples it 2 ns after the falling edge on which it drove the strobe. Writes and ticks act on the next rising edge, so their effect is first visible to a read issued on the falling edge after that. The status toggle flips on the rising edge that ends a status read, which means the next status read must show the inverted bit. The bench's model updates its state exactly when each write, tick or read task finishes, so each expected value matches that timing.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;
   localparam int CMD_AW = 11;
   localparam logic [CMD_AW-1:0] UL_ADDR_A = 11'h555;
   localparam logic [CMD_AW-1:0] UL_ADDR_B = 11'h2AA;
   localparam logic [7:0] UL_DATA_A = 8'hAA;
   localparam logic [7:0] UL_DATA_B = 8'h55;
   localparam logic [7:0] CMD_SETUP = 8'h80;
   localparam logic [7:0] CMD_CHIP  = 8'h10;
   localparam logic [7:0] CMD_SECT  = 8'h30;

   typedef enum logic [2:0] {
      ST_READ,
      ST_UL1,
      ST_UL2,
      ST_SETUP,
      ST_UL4,
      ST_UL5,
      ST_WIN,
      ST_BUSY
   } es_state_t;
endpackage

// File: rtl/erase_tick_counter.sv
module erase_tick_counter #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   input  logic tick,
   output logic expire
);
   localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   assign expire = run & ~restart & tick & (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run || restart || expire) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/erase_cmd_fsm.sv
module erase_cmd_fsm
   import nor_erase_pkg::*;
#(
   parameter int AW    = 16,
   parameter int SW    = 3,
   parameter int NSECT = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [7:0]       cmd_byte,
   input  logic             win_expire,
   input  logic             erase_expire,
   output es_state_t        state,
   output logic             win_restart,
   output logic [NSECT-1:0] pend,
   output logic [NSECT-1:0] erased
);
   localparam int LW = AW - SW;

   es_state_t        state_n;
   logic [NSECT-1:0] pend_n, erased_n, sect_bit;
   logic             at_a, at_b;

   assign at_a     = (wr_addr[LW-1:0] == LW'(UL_ADDR_A));
   assign at_b     = (wr_addr[LW-1:0] == LW'(UL_ADDR_B));
   assign sect_bit = NSECT'(1) << wr_addr[AW-1 -: SW];

   always_comb begin
      state_n     = state;
      pend_n      = pend;
      erased_n    = erased;
      win_restart = 1'b0;
      case (state)
         ST_READ:
            if (wr_en && at_a && cmd_byte == UL_DATA_A) state_n = ST_UL1;
         ST_UL1:
            if (wr_en) state_n = (at_b && cmd_byte == UL_DATA_B) ? ST_UL2 : ST_READ;
         ST_UL2:
            if (wr_en) state_n = (at_a && cmd_byte == CMD_SETUP) ? ST_SETUP : ST_READ;
         ST_SETUP:
            if (wr_en) state_n = (at_a && cmd_byte == UL_DATA_A) ? ST_UL4 : ST_READ;
         ST_UL4:
            if (wr_en) state_n = (at_b && cmd_byte == UL_DATA_B) ? ST_UL5 : ST_READ;
         ST_UL5:
            if (wr_en) begin
               if (at_a && cmd_byte == CMD_CHIP) begin
                  state_n = ST_BUSY;
                  pend_n  = '1;
               end else if (cmd_byte == CMD_SECT) begin
                  state_n     = ST_WIN;
                  pend_n      = sect_bit;
                  win_restart = 1'b1;
               end else begin
                  state_n = ST_READ;
               end
            end
         ST_WIN:
            if (wr_en) begin
               if (cmd_byte == CMD_SECT) begin
                  pend_n      = pend | sect_bit;
                  win_restart = 1'b1;
               end else begin
                  state_n = ST_READ;
                  pend_n  = '0;
               end
            end else if (win_expire) begin
               state_n = ST_BUSY;
            end
         ST_BUSY:
            if (erase_expire) begin
               state_n  = ST_READ;
               erased_n = erased | pend;
               pend_n   = '0;
            end
         default: state_n = ST_READ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_READ;
         pend   <= '0;
         erased <= '0;
      end else begin
         state  <= state_n;
         pend   <= pend_n;
         erased <= erased_n;
      end
   end
endmodule

// File: rtl/erase_status_word.sv
module erase_status_word #(
   parameter int LANES = 2
) (
   input  logic               toggle,
   input  logic               closed,
   output logic [8*LANES-1:0] word
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign word[8*g +: 8] = {1'b0, toggle, 2'b00, closed, 3'b000};
   end
endmodule

// File: rtl/nor_erase_front.sv
module nor_erase_front
   import nor_erase_pkg::*;
#(
   parameter int AW          = 16,
   parameter int LANES       = 2,
   parameter int SW          = 3,
   parameter int WIN_TICKS   = 1000,
   parameter int ERASE_TICKS = 4000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_addr,
   input  logic [8*LANES-1:0] wr_data,
   input  logic               rd_en,
   input  logic [AW-1:0]      rd_addr,
   input  logic [8*LANES-1:0] arr_rdata,
   output logic [8*LANES-1:0] rd_data
);
   localparam int DW    = 8 * LANES;
   localparam int NSECT = 1 << SW;

   if (AW - SW < CMD_AW) begin : g_bad_aw
      $error("nor_erase_front: AW-SW must cover the unlock address width");
   end
   if (SW < 1 || LANES < 1) begin : g_bad_shape
      $error("nor_erase_front: SW and LANES must be at least 1");
   end
   if (WIN_TICKS < 1 || ERASE_TICKS < 1) begin : g_bad_time
      $error("nor_erase_front: tick limits must be at least 1");
   end

   es_state_t        st;
   logic             st_win, st_busy, stat_mode;
   logic             win_restart, win_expire, erase_expire;
   logic             tog;
   logic [NSECT-1:0] pend, erased;
   logic [DW-1:0]    stat_word;
   logic             unused_rd_lo;

   assign unused_rd_lo = ^rd_addr[AW-SW-1:0];
   if (LANES > 1) begin : g_hi
      logic unused_wr_hi;
      assign unused_wr_hi = ^wr_data[DW-1:8];
   end

   erase_cmd_fsm #(.AW(AW), .SW(SW), .NSECT(NSECT)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .cmd_byte    (wr_data[7:0]),
      .win_expire  (win_expire),
      .erase_expire(erase_expire),
      .state       (st),
      .win_restart (win_restart),
      .pend        (pend),
      .erased      (erased)
   );

   assign st_win    = (st == ST_WIN);
   assign st_busy   = (st == ST_BUSY);
   assign stat_mode = st_win | st_busy;

   erase_tick_counter #(.LIMIT(WIN_TICKS)) u_win_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (st_win),
      .restart(win_restart | wr_en),
      .tick   (tick),
      .expire (win_expire)
   );

   erase_tick_counter #(.LIMIT(ERASE_TICKS)) u_busy_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (st_busy),
      .restart(1'b0),
      .tick   (tick),
      .expire (erase_expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tog <= 1'b0;
      else if (rd_en && stat_mode) tog <= ~tog;
   end

   erase_status_word #(.LANES(LANES)) u_stat (
      .toggle(tog),
      .closed(st_busy),
      .word  (stat_word)
   );

   always_comb begin
      if (stat_mode) rd_data = stat_word;
      else if (erased[rd_addr[AW-1 -: SW]]) rd_data = '1;
      else rd_data = arr_rdata;
   end
endmodule

// File: rtl/nor_erase_front_chk.sv
module nor_erase_front_chk #(
   parameter int DW    = 16,
   parameter int NSECT = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             wr_en,
   input logic [7:0]       cmd_byte,
   input logic             rd_en,
   input logic [DW-1:0]    rd_data,
   input logic [DW-1:0]    arr_rdata,
   input logic             st_win,
   input logic             st_busy,
   input logic             tog,
   input logic [NSECT-1:0] pend,
   input logic [NSECT-1:0] erased
);
   logic stat_mode;
   assign stat_mode = st_win | st_busy;

   assert_read_array_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !stat_mode && erased == '0) |-> rd_data == arr_rdata);

   assert_window_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_win && !tick) |=> !st_busy);

   assert_abort_to_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_win && wr_en && cmd_byte != 8'h30) |=> !(st_win || st_busy));

   assert_busy_pend_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      st_busy |=> (!st_busy || $stable(pend)));

   assert_status_bit7_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && stat_mode) |-> rd_data[7] == 1'b0);

   assert_toggle_flips_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && stat_mode) |=> tog != $past(tog));

   assert_erased_only_on_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !st_busy |=> $stable(erased));
endmodule

bind nor_erase_front nor_erase_front_chk #(.DW(DW), .NSECT(NSECT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .wr_en    (wr_en),
   .cmd_byte (wr_data[7:0]),
   .rd_en    (rd_en),
   .rd_data  (rd_data),
   .arr_rdata(arr_rdata),
   .st_win   (st_win),
   .st_busy  (st_busy),
   .tog      (tog),
   .pend     (pend),
   .erased   (erased)
);

// File: tb/nor_erase_front_tb.sv
module nor_erase_front_tb;
   localparam int AW = 16;
   localparam int LANES = 2;
   localparam int DW = 8 * LANES;
   localparam int WT = 5;
   localparam int ET = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic rd_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] arr_rdata = '0;
   logic [DW-1:0] rd_data;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   // bench model
   int ms;
   logic [7:0] mpend, mer;
   logic mtog;
   int wcnt, bcnt;

   always #10 clk = ~clk;

   nor_erase_front #(.AW(AW), .LANES(LANES), .SW(3), .WIN_TICKS(WT), .ERASE_TICKS(ET)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .arr_rdata(arr_rdata),
      .rd_data(rd_data)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a, input logic [DW-1:0] arr);
      logic [7:0] s;
      if (ms == 6 || ms == 7) begin
         s = {1'b0, mtog, 2'b00, (ms == 7), 3'b000};
         return {LANES{s}};
      end
      if (mer[a[15:13]]) return '1;
      return arr;
   endfunction

   task automatic m_write(input logic [AW-1:0] a, input logic [7:0] b);
      bit ia, ib;
      ia = (a[12:0] == 13'h555);
      ib = (a[12:0] == 13'h2AA);
      case (ms)
         0: ms = (ia && b == 8'hAA) ? 1 : 0;
         1: ms = (ib && b == 8'h55) ? 2 : 0;
         2: ms = (ia && b == 8'h80) ? 3 : 0;
         3: ms = (ia && b == 8'hAA) ? 4 : 0;
         4: ms = (ib && b == 8'h55) ? 5 : 0;
         5: begin
            if (ia && b == 8'h10) begin ms = 7; mpend = 8'hFF; bcnt = 0; end
            else if (b == 8'h30) begin ms = 6; mpend = 8'd1 << a[15:13]; wcnt = 0; end
            else ms = 0;
         end
         6: begin
            if (b == 8'h30) begin mpend = mpend | (8'd1 << a[15:13]); wcnt = 0; end
            else begin ms = 0; mpend = '0; end
         end
         default: ;
      endcase
   endtask

   task automatic m_tick();
      if (ms == 6) begin
         wcnt++;
         if (wcnt == WT) begin ms = 7; bcnt = 0; end
      end else if (ms == 7) begin
         bcnt++;
         if (bcnt == ET) begin ms = 0; mer = mer | mpend; mpend = '0; end
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; tick = 1'b0;
      ms = 0; mpend = '0; mer = '0; mtog = 1'b0; wcnt = 0; bcnt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] b);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = {$urandom(), b};
      @(negedge clk);
      wr_en = 1'b0;
      m_write(a, b);
   endtask

   task automatic tk(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
         m_tick();
      end
   endtask

   task automatic rd(input string req, input logic [AW-1:0] a);
      logic [DW-1:0] arr;
      arr = DW'($urandom());
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a; arr_rdata = arr;
      #2;
      chk(req, rd_data, exp_read(a, arr));
      @(negedge clk);
      rd_en = 1'b0;
      if (ms == 6 || ms == 7) mtog = ~mtog;
   endtask

   task automatic prefix();
      wr(16'h0555, 8'hAA);
      wr(16'h02AA, 8'h55);
      wr(16'h0555, 8'h80);
      wr(16'h0555, 8'hAA);
      wr(16'h02AA, 8'h55);
   endtask

   task automatic sect_erase(input logic [2:0] s);
      prefix();
      wr({s, 13'h0AB3}, 8'h30);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         nchk++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd24601));
      do_reset();
      // R1: reset state reads array data
      rd("R1", 16'h0000);
      rd("R1", 16'hE123);
      rd("R1", 16'h7FFF);

      // R3: wrong setup byte, then the tail of a sequence must not start erase
      wr(16'h0555, 8'hAA);
      wr(16'h02AA, 8'h55);
      wr(16'h0555, 8'h81);
      wr(16'h0555, 8'hAA);
      wr(16'h02AA, 8'h55);
      wr(16'h4555, 8'h30);
      rd("R3", 16'h4000);
      // R3: wrong unlock address
      wr(16'h0555, 8'hAA);
      wr(16'h02AB, 8'h55);
      rd("R3", 16'h0100);

      // R4 then R7: open window, abort with other command
      sect_erase(3'd2);
      rd("R4", 16'h4000);
      wr(16'h0555, 8'hF0);
      rd("R7", 16'h4010);
      tk(WT + ET + 2);
      rd("R7", 16'h4020);

      // R5 and R6: window timing and restart
      sect_erase(3'd1);
      tk(WT - 1);
      rd("R5", 16'h2000);
      wr(16'h8000, 8'h30);
      tk(WT - 1);
      rd("R6", 16'h2000);
      tk(1);
      rd("R5", 16'h2000);
      rd("R9", 16'h2000);

      // R8: writes while busy ignored
      wr(16'hC000, 8'h30);
      prefix();
      wr(16'h0555, 8'h10);
      tk(ET - 2);
      rd("R8", 16'h0000);
      tk(1);
      rd("R9", 16'h0000);
      tk(1);
      rd("R10", 16'h2004);
      rd("R10", 16'h8004);
      rd("R8", 16'hC004);
      rd("R10", 16'h0004);

      // random phase
      do_reset();
      for (int it = 0; it < 400; it++) begin
         int r;
         r = int'($urandom() % 10);
         if (r < 2) begin
            if ($urandom() % 4 == 0) begin
               wr(16'h0555, 8'hAA);
               wr(16'h02AA, 8'h5F);
            end else begin
               sect_erase(3'($urandom()));
            end
         end else if (r == 2) begin
            wr({3'($urandom()), 13'($urandom())}, 8'h30);
         end else if (r == 3) begin
            logic [7:0] b;
            logic [12:0] lo;
            case ($urandom() % 5)
               0: b = 8'hAA; 1: b = 8'h55; 2: b = 8'h80; 3: b = 8'hF0; default: b = 8'($urandom());
            endcase
            case ($urandom() % 3)
               0: lo = 13'h555; 1: lo = 13'h2AA; default: lo = 13'($urandom());
            endcase
            if (b == 8'h10) b = 8'h11;
            wr({3'($urandom()), lo}, b);
         end else if (r < 7) begin
            tk(1);
         end else begin
            rd("R9/R10 random", AW'($urandom()));
         end
      end

      // R2: whole-device erase
      do_reset();
      prefix();
      wr(16'h0555, 8'h10);
      rd("R2", 16'h0000);
      tk(ET);
      rd("R2", 16'h0000);
      rd("R10", 16'hFFFF);

      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule